// File: doc/BRIEF.md
# Snooping MSI Cache Line Controller

This block keeps coherent a group of small direct-mapped caches that share one snooping bus and one backing memory. Each cache line is invalid, shared or modified. Processors present read and write requests and hold them until the cache accepts them. A request that the line's state does not permit becomes a bus transaction. The other caches watch every transaction. They give up or downgrade their copies, and a cache that holds the line modified supplies the data in place of memory.

Each bus transaction completes in one clock. A round-robin arbiter picks one requesting cache per cycle. The memory model answers fetches unless a cache is supplying the data. It absorbs write-backs and the data a supplying cache puts on the bus. When a dirty line has to make room for another address, the write-back of that line goes out as its own transaction before the fetch.

Top module: `snoop_msi_sys`

## Requirements
- R1: After reset every line is invalid and no request is ready. The first access to any address therefore misses and puts a transaction on the bus.
- R2: On a read miss with no modified copy elsewhere, a read transaction (bus_cmd 1) is issued and memory supplies the data (bus_supply 0). The line is filled shared, so the next read of it completes with no bus transaction (bus_cmd 0).
- R3: A cache that holds a line shared takes no action when it snoops another cache's read of that line. Its own later reads of the line still complete without the bus.
- R4: A write to a shared or invalid line completes only in the cycle of a read-exclusive transaction (bus_cmd 2) from that cache. After that the line is modified, and further writes and reads complete with no bus transaction.
- R5: A cache that snoops a read-exclusive for a line it holds shared or modified invalidates the line. If the line was modified, it first supplies its data, which memory also stores. Its next access to that line misses.
- R6: A cache that holds a line modified and snoops another cache's read drives the line's data onto the bus with bus_supply 1, and memory does not drive. The owner's line becomes shared, so a later write by the owner needs a read-exclusive.
- R7: A requester served by a modified owner receives the owner's latest data and fills the line shared. Its next read of the line hits.
- R8: A miss that maps onto a modified line holding another address first issues a write-back (bus_cmd 3) of that line. During the write-back the request is not ready. The fetch follows, and memory afterwards returns the written-back value.
- R9: At most one transaction is on the bus per cycle, and bus_src names the granted cache. A request whose state grants no permission keeps cpu_ready low until its own read or read-exclusive occupies the bus. Two caches that miss in the same cycle are served in different cycles.
- R10: Memory contents after reset are (7*address+3) modulo 2^DW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | NCACHE | Request held per cache until accepted |
| cpu_write | input | NCACHE | 1 = write, 0 = read, per cache |
| cpu_addr | input | NCACHE*AW | Word address per cache; low IW bits select the line |
| cpu_wdata | input | NCACHE*DW | Write data per cache |
| cpu_ready | output | NCACHE | Request accepted this cycle |
| cpu_rdata | output | NCACHE*DW | Read data, valid with cpu_ready on a read |
| bus_cmd_o | output | 2 | 0 idle, 1 read, 2 read-exclusive, 3 write-back |
| bus_src_o | output | SW | Index of the cache that owns the bus this cycle |
| bus_addr_o | output | AW | Address of the bus transaction |
| bus_data_o | output | DW | Data on the bus (fetch data or write-back data) |
| bus_supply_o | output | 1 | A cache, not memory, is supplying the data |

## Verification
The bench builds two caches of four lines each over a 64-word memory with 8-bit data. With these sizes, addresses four words apart collide on one line, so dirty evictions, upgrades and transfers from a modified owner all come up within a handful of requests. A scripted sequence walks one line through every state transition, including a handover of a modified line between caches. A simultaneous miss by both caches exercises the arbiter. A long pseudo-random run over a few colliding addresses then compares every cycle's bus command, source, supply flag, ready and read data against the behavioural model.

// File: rtl/msi_pkg.sv
package msi_pkg;
  typedef enum logic [1:0] {
    LS_I = 2'd0,
    LS_S = 2'd1,
    LS_M = 2'd2
  } lstate_t;

  typedef enum logic [1:0] {
    BUS_IDLE = 2'd0,
    BUS_RD   = 2'd1,
    BUS_RDX  = 2'd2,
    BUS_WB   = 2'd3
  } bcmd_t;
endpackage

// File: rtl/msi_rr_arb.sv
module msi_rr_arb #(
  parameter int N = 2,
  localparam int SW = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  logic [SW-1:0] ptr_q;
  logic [SW-1:0] win;

  // lowest offset from the pointer wins; loop runs downward so it is written last
  always_comb begin : arb_c
    int j;
    gnt = '0;
    win = ptr_q;
    for (int k = N - 1; k >= 0; k--) begin
      j = (int'(ptr_q) + k) % N;
      if (req[j]) begin
        gnt    = '0;
        gnt[j] = 1'b1;
        win    = SW'(j);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ptr_q <= '0;
    else if (|req) ptr_q <= (win == SW'(N - 1)) ? '0 : win + 1'b1;
  end
endmodule

// File: rtl/msi_mem.sv
module msi_mem #(
  parameter int AW = 6,
  parameter int DW = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= DW'(i * 7 + 3);
    end else if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/msi_line_ctrl.sv
module msi_line_ctrl
  import msi_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 8,
  parameter int IW = 2,
  localparam int TW = AW - IW,
  localparam int NL = 1 << IW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cpu_valid,
  input  logic          cpu_write,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic          cpu_ready,
  output logic [DW-1:0] cpu_rdata,
  output logic          bus_req,
  output bcmd_t         bus_req_cmd,
  output logic [AW-1:0] bus_req_addr,
  output logic [DW-1:0] bus_req_data,
  input  logic          bus_gnt,
  input  logic          snoop_valid,
  input  bcmd_t         snoop_cmd,
  input  logic [AW-1:0] snoop_addr,
  input  logic [DW-1:0] bus_data,
  output logic          snoop_supply,
  output logic [DW-1:0] snoop_data
);
  lstate_t       st_q  [NL];
  logic [TW-1:0] tag_q [NL];
  logic [DW-1:0] dat_q [NL];

  logic [IW-1:0] c_idx, s_idx;
  logic [TW-1:0] c_tag, s_tag;
  logic c_perm, s_match, clash, hit, victim_dirty, take;

  assign c_idx = cpu_addr[IW-1:0];
  assign c_tag = cpu_addr[AW-1:IW];
  assign s_idx = snoop_addr[IW-1:0];
  assign s_tag = snoop_addr[AW-1:IW];

  always_comb begin
    c_perm       = (st_q[c_idx] != LS_I) && (tag_q[c_idx] == c_tag) &&
                   (!cpu_write || st_q[c_idx] == LS_M);
    s_match      = snoop_valid && (snoop_cmd == BUS_RD || snoop_cmd == BUS_RDX) &&
                   (st_q[s_idx] != LS_I) && (tag_q[s_idx] == s_tag);
    clash        = snoop_valid && (s_idx == c_idx);
    hit          = cpu_valid && c_perm && !clash;
    victim_dirty = (st_q[c_idx] == LS_M) && (tag_q[c_idx] != c_tag);
    bus_req      = cpu_valid && !c_perm;
    bus_req_cmd  = victim_dirty ? BUS_WB : (cpu_write ? BUS_RDX : BUS_RD);
    bus_req_addr = victim_dirty ? {tag_q[c_idx], c_idx} : cpu_addr;
    bus_req_data = dat_q[c_idx];
    take         = bus_gnt && bus_req;
    cpu_ready    = hit || (take && !victim_dirty);
    cpu_rdata    = hit ? dat_q[c_idx] : bus_data;
    snoop_supply = s_match && (st_q[s_idx] == LS_M);
    snoop_data   = dat_q[s_idx];
  end

  // line state: snoops and own grants never hit the same edge (one bus owner)
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NL; i++) st_q[i] <= LS_I;
    end else begin
      if (s_match) begin
        if (snoop_cmd == BUS_RDX) st_q[s_idx] <= LS_I;
        else if (st_q[s_idx] == LS_M) st_q[s_idx] <= LS_S;
      end
      if (take) begin
        if (victim_dirty) st_q[c_idx] <= LS_I;
        else st_q[c_idx] <= cpu_write ? LS_M : LS_S;
      end
    end
  end

  // tag and data arrays carry no reset so they can map onto RAM
  always_ff @(posedge clk) begin
    if (take && !victim_dirty) begin
      tag_q[c_idx] <= c_tag;
      dat_q[c_idx] <= cpu_write ? cpu_wdata : bus_data;
    end else if (hit && cpu_write) begin
      dat_q[c_idx] <= cpu_wdata;
    end
  end
endmodule

// File: rtl/snoop_msi_sys.sv
module snoop_msi_sys
  import msi_pkg::*;
#(
  parameter int NCACHE = 2,
  parameter int AW = 6,
  parameter int DW = 8,
  parameter int IW = 2,
  localparam int SW = (NCACHE > 1) ? $clog2(NCACHE) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NCACHE-1:0]    cpu_valid,
  input  logic [NCACHE-1:0]    cpu_write,
  input  logic [NCACHE*AW-1:0] cpu_addr,
  input  logic [NCACHE*DW-1:0] cpu_wdata,
  output logic [NCACHE-1:0]    cpu_ready,
  output logic [NCACHE*DW-1:0] cpu_rdata,
  output logic [1:0]           bus_cmd_o,
  output logic [SW-1:0]        bus_src_o,
  output logic [AW-1:0]        bus_addr_o,
  output logic [DW-1:0]        bus_data_o,
  output logic                 bus_supply_o
);
  logic [NCACHE-1:0] req, gnt, sup;
  bcmd_t             rcmd  [NCACHE];
  logic [AW-1:0]     raddr [NCACHE];
  logic [DW-1:0]     rdat  [NCACHE];
  logic [DW-1:0]     sdat  [NCACHE];

  bcmd_t         bus_cmd;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] wb_data, own_data, mem_rd, bus_data;
  logic [SW-1:0] bus_src;

  msi_rr_arb #(.N(NCACHE)) u_arb (.clk(clk), .rst(rst), .req(req), .gnt(gnt));

  always_comb begin
    bus_cmd  = BUS_IDLE;
    bus_addr = '0;
    bus_src  = '0;
    wb_data  = '0;
    own_data = '0;
    for (int k = 0; k < NCACHE; k++) begin
      if (gnt[k]) begin
        bus_cmd  = rcmd[k];
        bus_addr = raddr[k];
        bus_src  = SW'(k);
        wb_data  = rdat[k];
      end
      if (sup[k]) own_data = own_data | sdat[k];
    end
    bus_data = (|sup) ? own_data : ((bus_cmd == BUS_WB) ? wb_data : mem_rd);
  end

  msi_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk(clk), .rst(rst),
    .we((bus_cmd == BUS_WB) || (|sup)),
    .waddr(bus_addr),
    .wdata((bus_cmd == BUS_WB) ? wb_data : own_data),
    .raddr(bus_addr),
    .rdata(mem_rd)
  );

  for (genvar g = 0; g < NCACHE; g++) begin : g_cache
    msi_line_ctrl #(.AW(AW), .DW(DW), .IW(IW)) u_line (
      .clk(clk), .rst(rst),
      .cpu_valid(cpu_valid[g]),
      .cpu_write(cpu_write[g]),
      .cpu_addr(cpu_addr[g*AW +: AW]),
      .cpu_wdata(cpu_wdata[g*DW +: DW]),
      .cpu_ready(cpu_ready[g]),
      .cpu_rdata(cpu_rdata[g*DW +: DW]),
      .bus_req(req[g]),
      .bus_req_cmd(rcmd[g]),
      .bus_req_addr(raddr[g]),
      .bus_req_data(rdat[g]),
      .bus_gnt(gnt[g]),
      .snoop_valid((bus_cmd != BUS_IDLE) && !gnt[g]),
      .snoop_cmd(bus_cmd),
      .snoop_addr(bus_addr),
      .bus_data(bus_data),
      .snoop_supply(sup[g]),
      .snoop_data(sdat[g])
    );
  end

  assign bus_cmd_o    = bus_cmd;
  assign bus_src_o    = bus_src;
  assign bus_addr_o   = bus_addr;
  assign bus_data_o   = bus_data;
  assign bus_supply_o = |sup;
endmodule

// File: rtl/msi_sys_chk.sv
module msi_sys_chk #(
  parameter int NC = 2,
  parameter int SW = 1
) (
  input logic          clk,
  input logic          rst,
  input logic [NC-1:0] cpu_valid,
  input logic [NC-1:0] cpu_ready,
  input logic [1:0]    bus_cmd,
  input logic [SW-1:0] bus_src,
  input logic          bus_supply
);
  for (genvar g = 0; g < NC; g++) begin : g_rdy
    // R9: acceptance only for a presented request
    p_ready_needs_valid_r9: assert property (@(posedge clk) disable iff (rst)
      cpu_ready[g] |-> cpu_valid[g]);
  end

  // R6: a cache supplies data only during a fetch
  p_supply_on_fetch_r6: assert property (@(posedge clk) disable iff (rst)
    bus_supply |-> (bus_cmd == 2'd1 || bus_cmd == 2'd2));

  // R8: the write-back cycle never completes the request behind it
  p_wb_holds_request_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_cmd == 2'd3) |-> !cpu_ready[bus_src]);

  // R9: a fetch on the bus completes its owner's request
  p_fetch_completes_r9: assert property (@(posedge clk) disable iff (rst)
    (bus_cmd == 2'd1 || bus_cmd == 2'd2) |-> cpu_ready[bus_src]);

  // R2: an idle bus carries no cache supply
  p_idle_no_supply_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_cmd == 2'd0) |-> !bus_supply);
endmodule

bind snoop_msi_sys msi_sys_chk #(.NC(NCACHE), .SW(SW)) u_chk (
  .clk(clk), .rst(rst), .cpu_valid(cpu_valid), .cpu_ready(cpu_ready),
  .bus_cmd(bus_cmd_o), .bus_src(bus_src_o), .bus_supply(bus_supply_o)
);

// File: tb/snoop_msi_sys_tb.sv
module snoop_msi_sys_tb;
  localparam int NC = 2;
  localparam int AW = 6;
  localparam int DW = 8;
  localparam int IW = 2;
  localparam int NL = 1 << IW;
  localparam int SW = 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NC-1:0]    cpu_valid = '0;
  logic [NC-1:0]    cpu_write = '0;
  logic [NC*AW-1:0] cpu_addr  = '0;
  logic [NC*DW-1:0] cpu_wdata = '0;
  logic [NC-1:0]    cpu_ready;
  logic [NC*DW-1:0] cpu_rdata;
  logic [1:0]       bus_cmd_o;
  logic [SW-1:0]    bus_src_o;
  logic [AW-1:0]    bus_addr_o;
  logic [DW-1:0]    bus_data_o;
  logic             bus_supply_o;

  always #5 clk = ~clk;

  snoop_msi_sys #(.NCACHE(NC), .AW(AW), .DW(DW), .IW(IW)) u_dut (
    .clk(clk), .rst(rst), .cpu_valid(cpu_valid), .cpu_write(cpu_write),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
    .cpu_rdata(cpu_rdata), .bus_cmd_o(bus_cmd_o), .bus_src_o(bus_src_o),
    .bus_addr_o(bus_addr_o), .bus_data_o(bus_data_o), .bus_supply_o(bus_supply_o)
  );

  int checks = 0;
  int failures = 0;

  // behavioural model: 0 invalid, 1 shared, 2 modified
  int m_st  [NC][NL];
  int m_tag [NC][NL];
  int m_dat [NC][NL];
  int m_mem [1 << AW];
  int e_cmd [$];
  int e_sup [$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int c = 0; c < NC; c++)
      for (int i = 0; i < NL; i++) begin
        m_st[c][i] = 0; m_tag[c][i] = 0; m_dat[c][i] = 0;
      end
    for (int a = 0; a < (1 << AW); a++) m_mem[a] = (a * 7 + 3) & 255;  // R10
    e_cmd.delete(); e_sup.delete();
  endtask

  task automatic predict(input int c, input bit wr, input int a, input int wd, output int rd);
    int idx, tg, sup, data;
    idx = a % NL;
    tg  = a / NL;
    if (m_st[c][idx] != 0 && m_tag[c][idx] == tg && (!wr || m_st[c][idx] == 2)) begin
      rd = m_dat[c][idx];
      if (wr) m_dat[c][idx] = wd;
      return;
    end
    if (m_st[c][idx] == 2 && m_tag[c][idx] != tg) begin
      e_cmd.push_back(3); e_sup.push_back(0);
      m_mem[m_tag[c][idx] * NL + idx] = m_dat[c][idx];
      m_st[c][idx] = 0;
    end
    sup = 0;
    data = m_mem[a];
    for (int o = 0; o < NC; o++) begin
      if (o != c && m_st[o][idx] != 0 && m_tag[o][idx] == tg) begin
        if (m_st[o][idx] == 2) begin
          sup = 1; data = m_dat[o][idx]; m_mem[a] = data;
        end
        if (wr) m_st[o][idx] = 0;
        else if (m_st[o][idx] == 2) m_st[o][idx] = 1;
      end
    end
    e_cmd.push_back(wr ? 2 : 1); e_sup.push_back(sup);
    m_st[c][idx]  = wr ? 2 : 1;
    m_tag[c][idx] = tg;
    m_dat[c][idx] = wr ? wd : data;
    rd = data;
  endtask

  task automatic drive(input int c, input bit v, input bit wr, input int a, input int wd);
    cpu_valid[c] = v;
    cpu_write[c] = wr;
    cpu_addr[c*AW +: AW]  = AW'(a);
    cpu_wdata[c*DW +: DW] = DW'(wd);
  endtask

  // one request at a time, compared against the model on every cycle
  task automatic run_req(input int c, input bit wr, input int a, input int wd, input string req);
    int rd, ec, es;
    bit done, exp_rdy;
    predict(c, wr, a, wd, rd);
    drive(c, 1'b1, wr, a, wd);
    done = 0;
    for (int cyc = 0; cyc < 8 && !done; cyc++) begin
      @(negedge clk);
      ec = (e_cmd.size() > 0) ? e_cmd.pop_front() : 0;
      es = (e_sup.size() > 0) ? e_sup.pop_front() : 0;
      exp_rdy = (e_cmd.size() == 0);
      chk(bus_cmd_o == 2'(ec), req, int'(bus_cmd_o), ec);
      if (ec != 0) begin
        chk(bus_src_o == SW'(c), req, int'(bus_src_o), c);
        chk(bus_supply_o == 1'(es), req, int'(bus_supply_o), es);
      end
      chk(cpu_ready[c] == exp_rdy, req, int'(cpu_ready[c]), int'(exp_rdy));
      if (cpu_ready[c]) begin
        if (!wr) chk(cpu_rdata[c*DW +: DW] == DW'(rd), req, int'(cpu_rdata[c*DW +: DW]), rd);
        done = 1;
      end
      @(posedge clk); #1;
    end
    if (!done) chk(1'b0, req, 0, 1);
    drive(c, 1'b0, 1'b0, 0, 0);
    e_cmd.delete(); e_sup.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog act=0 exp=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int seed, rd, w, o;
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(cpu_ready == '0, "R1", int'(cpu_ready), 0);
    chk(bus_cmd_o == 2'd0, "R1", int'(bus_cmd_o), 0);
    @(posedge clk); #1;

    run_req(0, 0, 5, 0, "R1");          // cold miss, memory value
    run_req(0, 0, 5, 0, "R2");          // hit in shared
    run_req(1, 0, 5, 0, "R3");          // c0 shared sees read, no action
    run_req(0, 0, 5, 0, "R3");
    run_req(0, 1, 5, 8'h11, "R4");      // upgrade needs read-exclusive
    run_req(0, 1, 5, 8'h22, "R4");      // modified: write hit
    run_req(0, 0, 5, 0, "R4");
    run_req(1, 0, 5, 0, "R6");          // owner supplies 0x22
    run_req(1, 0, 5, 0, "R7");
    run_req(0, 0, 5, 0, "R6");
    run_req(0, 1, 5, 8'h33, "R6");      // owner downgraded, write needs bus
    run_req(1, 0, 5, 0, "R5");          // c1 was invalidated
    run_req(1, 1, 5, 8'h44, "R5");
    run_req(0, 1, 5, 8'h55, "R5");      // modified copy snoops write
    run_req(1, 0, 5, 0, "R5");
    run_req(1, 1, 5, 8'h66, "R4");
    run_req(1, 0, 9, 0, "R8");          // dirty victim written back first
    run_req(0, 0, 5, 0, "R8");          // memory now returns 0x66
    run_req(1, 1, 13, 8'h77, "R4");

    // R9: simultaneous misses are served one per cycle
    drive(0, 1'b1, 1'b0, 2, 0);
    drive(1, 1'b1, 1'b0, 2, 0);
    @(negedge clk);
    chk($countones(cpu_ready) == 1, "R9", $countones(cpu_ready), 1);
    chk(bus_cmd_o == 2'd1, "R9", int'(bus_cmd_o), 1);
    w = cpu_ready[1] ? 1 : 0;
    o = 1 - w;
    chk(cpu_rdata[w*DW +: DW] == DW'(m_mem[2]), "R9", int'(cpu_rdata[w*DW +: DW]), m_mem[2]);
    @(posedge clk); #1;
    drive(w, 1'b0, 1'b0, 0, 0);
    @(negedge clk);
    chk(cpu_ready[o] == 1'b1, "R9", int'(cpu_ready[o]), 1);
    chk(bus_src_o == SW'(o), "R9", int'(bus_src_o), o);
    chk(cpu_rdata[o*DW +: DW] == DW'(m_mem[2]), "R9", int'(cpu_rdata[o*DW +: DW]), m_mem[2]);
    @(posedge clk); #1;
    drive(o, 1'b0, 1'b0, 0, 0);
    predict(w, 0, 2, 0, rd);
    predict(o, 0, 2, 0, rd);
    e_cmd.delete(); e_sup.delete();

    // pseudo-random run over colliding addresses
    seed = 12345;
    for (int n = 0; n < 300; n++) begin
      int a;
      seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
      a = ((seed >> 8) % 3) * NL + 1 + ((seed >> 12) % 2) * 2;
      run_req((seed >> 4) % NC, ((seed >> 6) % 2) == 1, a, (seed >> 16) & 255, "R9");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule